// File: doc/BRIEF.md
# Video Black-Level Clamp Controller

This block watches the digitised black level of two video channels, one carrying luminance and one carrying chrominance. It tells an external charge pump whether to raise or lower the DC level stored on each channel's input coupling capacitor. A line-rate strobe marks a short window on the back porch. While the strobe is high, the first eight samples of each channel are summed. When the strobe falls, the average of those samples is compared with that channel's fixed black target. The result is turned into a short train of single-cycle pulses on either the up or the down output. The size of the error sets how many pulses are sent, up to a limit.

A vertical blanking flag freezes the loop. While it is high, a window that closes produces no correction, and any pulse train already running is cancelled.

Top module: `vclamp_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all four pulse outputs are low.
- R2: The luminance target is code 60 and the chrominance target is code 128. Each channel's average is the sum of the first 8 samples taken while `clamp_win` is high, shifted right by 3 (floor).
- R3: An average that lies within one code of the target (difference -1, 0 or +1) produces no pulse on that channel.
- R4: An average below the target produces pulses only on the channel's up output. An average above the target produces pulses only on its down output.
- R5: The number of pulses in a train is the absolute difference minus one, limited to 8.
- R6: Each pulse is one cycle high and is followed by at least one low cycle. Pulses repeat every second cycle. If `clamp_win` is first seen low at clock edge k, the first pulse is driven high at edge k+1.
- R7: The up and down outputs of a channel are never high in the same cycle.
- R8: A window that holds fewer than 8 samples produces no pulse.
- R9: If `vblank` is high at the edge where the window's end is seen, no pulse follows. `vblank` high at any edge drives all outputs low from that edge on, and cancels the rest of a running train.
- R10: Samples taken while `clamp_win` is low, and samples after the eighth in a window, have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| luma_in | input | 8 | Luminance ADC sample |
| chroma_in | input | 8 | Chrominance ADC sample |
| clamp_win | input | 1 | Back-porch clamp window strobe |
| vblank | input | 1 | Vertical blanking freeze flag |
| luma_up | output | 1 | Luminance clamp-up pulse |
| luma_dn | output | 1 | Luminance clamp-down pulse |
| chroma_up | output | 1 | Chrominance clamp-up pulse |
| chroma_dn | output | 1 | Chrominance clamp-down pulse |

## Verification
Directed lines use a constant level set exactly on the target, one code off, two codes off and far off. These separate the dead band from the smallest correction, and separate the correction count from its cap, in both directions on each channel. Short windows, and windows whose tail samples are extreme, show that only the first eight in-window samples count. Junk samples driven between windows show that out-of-window data is ignored. Blanking is applied both at the window end and in the middle of a train, which separates a dropped decision from a cancelled one. Random lines with level noise around each target then cover the averaging and rounding against a bench model.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;
  localparam int SMP_W     = 8;
  localparam int MAX_STEPS = 8;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [STEP_W-1:0] step_t;

  // number of correction pulses for a given average against a target
  function automatic step_t steps_for(smp_t avg, smp_t tgt);
    smp_t mag;
    mag = (avg > tgt) ? smp_t'(avg - tgt) : smp_t'(tgt - avg);
    if (mag <= smp_t'(1)) return '0;
    if (smp_t'(mag - smp_t'(1)) >= smp_t'(MAX_STEPS)) return step_t'(MAX_STEPS);
    return step_t'(mag - smp_t'(1));
  endfunction

  // direction: raise the level when the black sits below target
  function automatic logic wants_up(smp_t avg, smp_t tgt);
    return avg < tgt;
  endfunction
endpackage

// File: rtl/vclamp_acc.sv
module vclamp_acc
  import vclamp_pkg::*;
#(
  parameter int   AVG_LOG2 = 3,
  parameter smp_t TGT      = 8'd60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  smp_t  smp,
  input  logic  win,
  input  logic  win_fall,
  input  logic  vblank,
  output logic  dec_vld,
  output logic  dec_up,
  output step_t dec_steps
);
  localparam int SUM_W = SMP_W + AVG_LOG2;
  localparam int CNT_W = AVG_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << AVG_LOG2;

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  smp_t             avg;

  assign full = (cnt_q == FULL);
  assign avg  = smp_t'(sum_q >> AVG_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (win_fall) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (win && !full) begin
      sum_q <= sum_q + SUM_W'(smp);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dec_vld   = win_fall && full && !vblank;
  assign dec_up    = wants_up(avg, TGT);
  assign dec_steps = steps_for(avg, TGT);
endmodule

// File: rtl/vclamp_pulse.sv
module vclamp_pulse
  import vclamp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  load_up,
  input  step_t load_steps,
  input  logic  vblank,
  output logic  up,
  output logic  dn
);
  step_t left_q;
  logic  dir_q;
  logic  ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      dir_q  <= 1'b0;
      ph_q   <= 1'b0;
      up     <= 1'b0;
      dn     <= 1'b0;
    end else if (vblank) begin
      left_q <= '0;
      ph_q   <= 1'b0;
      up     <= 1'b0;
      dn     <= 1'b0;
    end else if (load) begin
      left_q <= load_steps;
      dir_q  <= load_up;
      ph_q   <= 1'b0;
      up     <= 1'b0;
      dn     <= 1'b0;
    end else if (left_q != '0 && !ph_q) begin
      up     <= dir_q;
      dn     <= !dir_q;
      ph_q   <= 1'b1;
      left_q <= left_q - 1'b1;
    end else begin
      up   <= 1'b0;
      dn   <= 1'b0;
      ph_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vclamp_ctrl.sv
module vclamp_ctrl
  import vclamp_pkg::*;
#(
  parameter int   AVG_LOG2   = 3,
  parameter smp_t LUMA_TGT   = 8'd60,
  parameter smp_t CHROMA_TGT = 8'd128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] luma_in,
  input  logic [7:0] chroma_in,
  input  logic       clamp_win,
  input  logic       vblank,
  output logic       luma_up,
  output logic       luma_dn,
  output logic       chroma_up,
  output logic       chroma_dn
);
  localparam int NCH = 2;

  logic  win_q;
  logic  win_fall;
  smp_t  ch_smp   [NCH];
  logic  ch_vld   [NCH];
  logic  ch_dirup [NCH];
  step_t ch_steps [NCH];
  logic  ch_up    [NCH];
  logic  ch_dn    [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= clamp_win;
  end

  assign win_fall  = win_q && !clamp_win;
  assign ch_smp[0] = luma_in;
  assign ch_smp[1] = chroma_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam smp_t TGT_C = (c == 0) ? LUMA_TGT : CHROMA_TGT;

    vclamp_acc #(.AVG_LOG2(AVG_LOG2), .TGT(TGT_C)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (ch_smp[c]),
      .win      (clamp_win),
      .win_fall (win_fall),
      .vblank   (vblank),
      .dec_vld  (ch_vld[c]),
      .dec_up   (ch_dirup[c]),
      .dec_steps(ch_steps[c])
    );

    vclamp_pulse u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ch_vld[c]),
      .load_up   (ch_dirup[c]),
      .load_steps(ch_steps[c]),
      .vblank    (vblank),
      .up        (ch_up[c]),
      .dn        (ch_dn[c])
    );
  end

  assign luma_up   = ch_up[0];
  assign luma_dn   = ch_dn[0];
  assign chroma_up = ch_up[1];
  assign chroma_dn = ch_dn[1];
endmodule

// File: rtl/vclamp_chk.sv
module vclamp_chk (
  input logic clk,
  input logic rst_n,
  input logic vblank,
  input logic win_fall,
  input logic luma_up,
  input logic luma_dn,
  input logic chroma_up,
  input logic chroma_dn
);
  logic [4:0] l_cnt;
  logic [4:0] c_cnt;

  // pulses seen since the last window end, per channel
  always_ff @(posedge clk) begin
    if (!rst_n || win_fall) begin
      l_cnt <= '0;
      c_cnt <= '0;
    end else begin
      if ((luma_up || luma_dn) && l_cnt != 5'd31)     l_cnt <= l_cnt + 1'b1;
      if ((chroma_up || chroma_dn) && c_cnt != 5'd31) c_cnt <= c_cnt + 1'b1;
    end
  end

  assert_luma_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(luma_up && luma_dn));
  assert_chroma_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(chroma_up && chroma_dn));
  assert_luma_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_up || luma_dn) |=> !(luma_up || luma_dn));
  assert_chroma_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma_up || chroma_dn) |=> !(chroma_up || chroma_dn));
  assert_blank_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> !(luma_up || luma_dn || chroma_up || chroma_dn));
  assert_step_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cnt <= 5'd8) && (c_cnt <= 5'd8));
endmodule

bind vclamp_ctrl vclamp_chk u_vclamp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vblank   (vblank),
  .win_fall (win_fall),
  .luma_up  (luma_up),
  .luma_dn  (luma_dn),
  .chroma_up(chroma_up),
  .chroma_dn(chroma_dn)
);

// File: tb/test_vclamp_ctrl.sv
`timescale 1ns/1ps
module test_vclamp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] luma_in = 8'd0;
  logic [7:0] chroma_in = 8'd0;
  logic       clamp_win = 1'b0;
  logic       vblank = 1'b0;
  logic       luma_up, luma_dn, chroma_up, chroma_dn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vclamp_ctrl i_vclamp_ctrl (
    .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .chroma_in(chroma_in),
    .clamp_win(clamp_win), .vblank(vblank),
    .luma_up(luma_up), .luma_dn(luma_dn),
    .chroma_up(chroma_up), .chroma_dn(chroma_dn)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected signed pulse count: +n means up pulses, -n down pulses
  function automatic int model(int sum8, int tgt);
    int avg, diff, mag, n;
    avg  = sum8 / 8;
    diff = avg - tgt;
    mag  = (diff < 0) ? -diff : diff;
    if (mag < 2) return 0;
    n = mag - 1;
    if (n > 8) n = 8;
    return (diff < 0) ? n : -n;
  endfunction

  function automatic logic [7:0] clip(int v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'd255;
    return v[7:0];
  endfunction

  task automatic run_line(int len, int lb, int cb, int spread, int tail,
                          bit vb_end, int mid_vb, string req);
    int lsum = 0, csum = 0, el, ec;
    int lu = 0, ld = 0, cu = 0, cd = 0, lfirst = 0, cfirst = 0;
    bit lprev = 0, cprev = 0, excl_bad = 0, gap_bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      clamp_win = 1'b1;
      if (i >= 8 && tail >= 0) begin
        luma_in = clip(tail); chroma_in = clip(tail);
      end else begin
        luma_in   = clip(lb + int'($urandom_range(2*spread)) - spread);
        chroma_in = clip(cb + int'($urandom_range(2*spread)) - spread);
      end
      if (i < 8) begin lsum += luma_in; csum += chroma_in; end
    end
    @(negedge clk);
    clamp_win = 1'b0;
    vblank = vb_end;
    luma_in = 8'($urandom); chroma_in = 8'($urandom);
    el = (len >= 8 && !vb_end) ? model(lsum, 60) : 0;
    ec = (len >= 8 && !vb_end) ? model(csum, 128) : 0;
    if (mid_vb != 0) begin el = (el != 0) ? el / ((el < 0) ? -el : el) : 0;
                           ec = (ec != 0) ? ec / ((ec < 0) ? -ec : ec) : 0; end
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (luma_up && luma_dn) excl_bad = 1;
      if (chroma_up && chroma_dn) excl_bad = 1;
      if ((luma_up || luma_dn) && lprev) gap_bad = 1;
      if ((chroma_up || chroma_dn) && cprev) gap_bad = 1;
      if ((luma_up || luma_dn) && lfirst == 0) lfirst = i;
      if ((chroma_up || chroma_dn) && cfirst == 0) cfirst = i;
      lu += int'(luma_up); ld += int'(luma_dn);
      cu += int'(chroma_up); cd += int'(chroma_dn);
      lprev = luma_up || luma_dn; cprev = chroma_up || chroma_dn;
      if (i == 1) vblank = 1'b0;
      if (mid_vb != 0 && i == mid_vb) vblank = 1'b1;
      if (mid_vb != 0 && i == mid_vb + 2) vblank = 1'b0;
      luma_in = 8'($urandom); chroma_in = 8'($urandom);
    end
    check(lu - ld == el && (lu == 0 || ld == 0), req, "luma up-down count", lu - ld, el);
    check(cu - cd == ec && (cu == 0 || cd == 0), req, "chroma up-down count", cu - cd, ec);
    check(!excl_bad, "R7", "up and down together", int'(excl_bad), 0);
    check(!gap_bad, "R6", "back-to-back pulse", int'(gap_bad), 0);
    if (el != 0) check(lfirst == 2, "R6", "luma first pulse slot", lfirst, 2);
    if (ec != 0) check(cfirst == 2, "R6", "chroma first pulse slot", cfirst, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({luma_up, luma_dn, chroma_up, chroma_dn} == 4'b0, "R1", "outputs in reset",
          int'({luma_up, luma_dn, chroma_up, chroma_dn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({luma_up, luma_dn, chroma_up, chroma_dn} == 4'b0, "R1", "outputs after reset",
          int'({luma_up, luma_dn, chroma_up, chroma_dn}), 0);
    void'($urandom(32'd1234));
    run_line(8, 60, 128, 0, -1, 0, 0, "R3");    // on target
    run_line(8, 61, 127, 0, -1, 0, 0, "R3");    // one code off, dead band
    run_line(8, 59, 129, 0, -1, 0, 0, "R3");
    run_line(8, 62, 126, 0, -1, 0, 0, "R4");    // smallest correction
    run_line(8, 57, 137, 0, -1, 0, 0, "R5");    // 2 up, 8 down
    run_line(8, 50, 140, 0, -1, 0, 0, "R5");    // capped both
    run_line(10, 10, 250, 0, -1, 0, 0, "R2");   // far off, targets
    run_line(7, 20, 200, 0, -1, 0, 0, "R8");    // short window
    run_line(14, 60, 128, 0, 255, 0, 0, "R10"); // extreme tail ignored
    run_line(8, 20, 200, 0, -1, 1, 0, "R9");    // blank at window end
    run_line(8, 20, 200, 0, -1, 0, 3, "R9");    // blank mid train
    for (int n = 0; n < 300; n++) begin
      int len;
      len = 5 + int'($urandom_range(9));
      run_line(len, 60 + int'($urandom_range(24)) - 12, 128 + int'($urandom_range(24)) - 12,
               int'($urandom_range(6)), -1, ($urandom_range(7) == 0), 0, "R5");
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule